// File: doc/BRIEF.md
# Exception Entry State Save Unit

This unit performs the register bookkeeping a processor core needs when it commits to taking an exception. The core raises a one-cycle "take" strobe together with a code for the exception kind. On that edge the unit captures the resume address into the save/restore address register (SRR0). It stores the lower half of the current machine state word into the save/restore status register (SRR1). It builds the new machine state word, and it forms the address of the first handler instruction.

Two exception kinds are handled: the decrementer timer and the system call. In the new state word the interrupt-prefix and machine-check-enable bits are preserved. The little-endian mode bit is reloaded from the interrupt-little-endian bit, and every other bit is cleared. Bit positions use big-endian numbering, where bit 0 is the most significant bit and signal index = 31 − bit number. Prioritisation, pipeline draining and the return path belong to other blocks.

Top module: `exc_entry_save`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first strobe, `srr0_o`, `srr1_o`, `msr_o` and `vector_o` are all zero.
- R2: On a clock edge with `take_i` high, `srr0_o` becomes the `next_ea_i` value present at that edge.
- R3: On a taking edge, `srr1_o[15:0]` (big-endian bits 16..31) becomes `msr_i[15:0]`.
- R4: On a taking edge, `srr1_o[31:16]` (big-endian bits 0..15) becomes zero, for both `kind_i` = 0 (decrementer) and `kind_i` = 1 (system call).
- R5: On a taking edge, `msr_o[6]` (IP, bit 25) and `msr_o[12]` (ME, bit 19) take the values of `msr_i[6]` and `msr_i[12]`.
- R6: On a taking edge, `msr_o[0]` (LE, bit 31) takes the prior value of `msr_i[16]` (ILE, bit 15).
- R7: On a taking edge, every `msr_o` bit other than indices 0, 6 and 12 becomes zero. This includes EE (`msr_o[15]`) and ILE (`msr_o[16]`).
- R8: On a taking edge, `vector_o` becomes the base plus an offset. The base is 0x00000000 when `msr_i[6]` is 0 and 0xFFF00000 when it is 1. The offset is 0x900 for `kind_i` = 0 and 0xC00 for `kind_i` = 1.
- R9: On an edge with `take_i` low, all four outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception committed this cycle |
| kind_i | input | 1 | 0 = decrementer, 1 = system call |
| msr_i | input | 32 | Current machine state word |
| next_ea_i | input | 32 | Address of the instruction that would run next |
| srr0_o | output | 32 | Saved resume address |
| srr1_o | output | 32 | Saved status word |
| msr_o | output | 32 | New machine state word |
| vector_o | output | 32 | Handler fetch address |

## Verification
The bench applies state words with the interrupt-little-endian bit set while the little-endian bit is clear, and the reverse. A unit that copied the old LE bit, instead of reloading it from ILE, shows the wrong `msr_o[0]`.

All-ones state words expose any bit that leaks into SRR1's upper half or into the cleared MSR field. EE is the most likely bit to leak. Both prefix settings are crossed with both kinds, so a swapped offset or a wrong base shows up in `vector_o`.

Idle cycles carry random inputs and back-to-back strobes. A unit that updates without a strobe, or that lags one strobe behind, is caught.

// File: rtl/exc_save_pkg.sv
package exc_save_pkg;
   typedef enum logic {
      EXC_DEC     = 1'b0,
      EXC_SYSCALL = 1'b1
   } exc_kind_e;

   // big-endian bit number to vector index
   function automatic int be2idx(input int be, input int width);
      return width - 1 - be;
   endfunction
endpackage

// File: rtl/exc_srr_build.sv
module exc_srr_build #(
   parameter int XLEN      = 32,
   parameter int SAVE_FROM = 16   // first big-endian bit copied into SRR1
) (
   input  logic [XLEN-1:0] state_i,
   input  logic [XLEN-1:0] ea_i,
   output logic [XLEN-1:0] srr0_nx_o,
   output logic [XLEN-1:0] srr1_nx_o
);
   localparam int KEEP_W = XLEN - SAVE_FROM;

   if (SAVE_FROM < 1 || SAVE_FROM >= XLEN) begin : g_bad_cut
      $error("SAVE_FROM out of range");
   end

   assign srr0_nx_o = ea_i;

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i < KEEP_W) begin : g_copy
         assign srr1_nx_o[i] = state_i[i];
      end else begin : g_zero
         assign srr1_nx_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/exc_msr_build.sv
module exc_msr_build #(
   parameter int XLEN   = 32,
   parameter int ILE_BE = 15,
   parameter int ME_BE  = 19,
   parameter int IP_BE  = 25,
   parameter int LE_BE  = 31
) (
   input  logic [XLEN-1:0] state_i,
   output logic [XLEN-1:0] state_nx_o
);
   import exc_save_pkg::*;
   localparam int ILE_IX = be2idx(ILE_BE, XLEN);

   if (ILE_BE >= XLEN || ME_BE >= XLEN || IP_BE >= XLEN || LE_BE >= XLEN)
   begin : g_bad_pos
      $error("MSR bit position outside word");
   end
   if (LE_BE == ME_BE || LE_BE == IP_BE || ME_BE == IP_BE) begin : g_clash
      $error("MSR bit positions overlap");
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      localparam int BE = XLEN - 1 - i;
      if (BE == ME_BE || BE == IP_BE) begin : g_keep
         assign state_nx_o[i] = state_i[i];
      end else if (BE == LE_BE) begin : g_reload
         assign state_nx_o[i] = state_i[ILE_IX];
      end else begin : g_clear
         assign state_nx_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
   parameter int          XLEN    = 32,
   parameter int          IP_BE   = 25,
   parameter logic [31:0] BASE_LO = 32'h0000_0000,
   parameter logic [31:0] BASE_HI = 32'hFFF0_0000,
   parameter logic [31:0] OFF_DEC = 32'h0000_0900,
   parameter logic [31:0] OFF_SC  = 32'h0000_0C00
) (
   input  logic [XLEN-1:0] state_i,
   input  logic            kind_i,
   output logic [XLEN-1:0] vec_nx_o
);
   import exc_save_pkg::*;
   localparam int          IP_IX    = be2idx(IP_BE, XLEN);
   localparam logic [31:0] OFF_SPAN = OFF_DEC | OFF_SC;
   localparam bit          DISJOINT = ((BASE_LO | BASE_HI) & OFF_SPAN) == 32'h0;

   if (XLEN != 32) begin : g_bad_w
      $error("vector constants assume a 32-bit word");
   end

   logic [XLEN-1:0] base_w, off_w;
   assign base_w = state_i[IP_IX] ? BASE_HI : BASE_LO;
   assign off_w  = (exc_kind_e'(kind_i) == EXC_SYSCALL) ? OFF_SC : OFF_DEC;

   if (DISJOINT) begin : g_or
      assign vec_nx_o = base_w | off_w;
   end else begin : g_add
      assign vec_nx_o = base_w + off_w;
   end
endmodule

// File: rtl/exc_entry_save.sv
module exc_entry_save #(
   parameter int XLEN      = 32,
   parameter int SAVE_FROM = 16,
   parameter int ILE_BE    = 15,
   parameter int ME_BE     = 19,
   parameter int IP_BE     = 25,
   parameter int LE_BE     = 31
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            take_i,
   input  logic            kind_i,
   input  logic [31:0]     msr_i,
   input  logic [31:0]     next_ea_i,
   output logic [31:0]     srr0_o,
   output logic [31:0]     srr1_o,
   output logic [31:0]     msr_o,
   output logic [31:0]     vector_o
);
   localparam int ILE_IX = XLEN - 1 - ILE_BE;
   localparam int LE_IX  = XLEN - 1 - LE_BE;

   if (XLEN != 32) begin : g_bad_w
      $error("port widths fixed at 32");
   end

   logic [XLEN-1:0] srr0_nx, srr1_nx, msr_nx, vec_nx;

   exc_srr_build #(.XLEN(XLEN), .SAVE_FROM(SAVE_FROM)) u_srr (
      .state_i  (msr_i),
      .ea_i     (next_ea_i),
      .srr0_nx_o(srr0_nx),
      .srr1_nx_o(srr1_nx)
   );

   exc_msr_build #(.XLEN(XLEN), .ILE_BE(ILE_BE), .ME_BE(ME_BE),
                   .IP_BE(IP_BE), .LE_BE(LE_BE)) u_msr (
      .state_i   (msr_i),
      .state_nx_o(msr_nx)
   );

   exc_vec_gen #(.XLEN(XLEN), .IP_BE(IP_BE)) u_vec (
      .state_i (msr_i),
      .kind_i  (kind_i),
      .vec_nx_o(vec_nx)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         srr0_o   <= '0;
         srr1_o   <= '0;
         msr_o    <= '0;
         vector_o <= '0;
      end else if (take_i) begin
         srr0_o   <= srr0_nx;
         srr1_o   <= srr1_nx;
         msr_o    <= msr_nx;
         vector_o <= vec_nx;
      end
   end

   // R2
   srr0_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> srr0_o == $past(next_ea_i));

   // R4
   srr1_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> srr1_o[31:16] == 16'h0);

   // R6
   le_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> msr_o[LE_IX] == $past(msr_i[ILE_IX]));

   // R8
   vec_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> vector_o[11:0] == ($past(kind_i) ? 12'hC00 : 12'h900));

   // R9
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_i |=> $stable(srr0_o) && $stable(srr1_o)
                  && $stable(msr_o) && $stable(vector_o));
endmodule

// File: tb/tb_exc_entry_save.sv
`timescale 1ns/1ps
module tb_exc_entry_save;
   typedef struct packed {
      logic [31:0] srr0, srr1, msr, vec;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0, take = 1'b0, kind = 1'b0;
   logic [31:0] msr = '0, ea = '0;
   logic [31:0] srr0_o, srr1_o, msr_o, vec_o;
   int          checks = 0, errors = 0;
   exp_t        q[$];
   exp_t        cur = '0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   exc_entry_save dut (
      .clk_i(clk), .rst_ni(rst_n), .take_i(take), .kind_i(kind),
      .msr_i(msr), .next_ea_i(ea), .srr0_o(srr0_o), .srr1_o(srr1_o),
      .msr_o(msr_o), .vector_o(vec_o)
   );

   task automatic chk(input string req, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // driver: apply one cycle of stimulus, push the expected state after it
   task automatic step(input logic t, input logic k, input logic [31:0] m, input logic [31:0] a);
      @(negedge clk);
      take = t; kind = k; msr = m; ea = a;
      if (t) begin
         cur.srr0 = a;
         cur.srr1 = {16'h0, m[15:0]};
         cur.msr  = '0;
         cur.msr[6]  = m[6];
         cur.msr[12] = m[12];
         cur.msr[0]  = m[16];
         cur.vec  = (m[6] ? 32'hFFF0_0000 : 32'h0) + (k ? 32'hC00 : 32'h900);
      end
      q.push_back(cur);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk("R2/R9 srr0", srr0_o, e.srr0);
         chk("R3/R9 srr1 low", {16'h0, srr1_o[15:0]}, {16'h0, e.srr1[15:0]});
         chk("R4 srr1 high", {srr1_o[31:16], 16'h0}, {e.srr1[31:16], 16'h0});
         chk("R5 IP/ME", msr_o & 32'h0000_1040, e.msr & 32'h0000_1040);
         chk("R6 LE", {31'h0, msr_o[0]}, {31'h0, e.msr[0]});
         chk("R7 cleared", msr_o & ~32'h0000_1041, e.msr & ~32'h0000_1041);
         chk("R8 vector", vec_o, e.vec);
      end
   end

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 srr0", srr0_o, 32'h0);
      chk("R1 srr1", srr1_o, 32'h0);
      chk("R1 msr", msr_o, 32'h0);
      chk("R1 vector", vec_o, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      // idle after reset with busy inputs: still zero (R1, R9)
      step(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
      // decrementer, prefix 0, ILE 1 / LE 0
      step(1'b1, 1'b0, 32'h0001_8000, 32'h0000_1234);
      // system call, prefix 1, everything set
      step(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0004);
      // system call, prefix 0, ILE 0, LE 1, EE 1
      step(1'b1, 1'b1, 32'h0000_9001, 32'h0000_2000);
      // decrementer, prefix 1, only IP and ME
      step(1'b1, 1'b0, 32'h0000_1040, 32'hFFFF_FFFC);
      // holds with random inputs
      for (int i = 0; i < 20; i++)
         step(1'b0, 1'($urandom), $urandom, $urandom);
      // randomized mix including back-to-back strobes
      for (int i = 0; i < 200; i++)
         step(1'($urandom % 3 != 0), 1'($urandom), $urandom, $urandom);
      step(1'b0, 1'b0, 32'h0, 32'h0);
      @(posedge clk); #2;
      done = 1'b1;
      summary();
   end
endmodule